// File: doc/BRIEF.md
# Circular-buffer address generator for DSP data memory

This block turns the base addresses a DSP core issues into physical data-RAM addresses, so that delay lines and filter state behave as circular buffers and no sample ever has to be copied. A configuration value splits the data memory in two. The lower part, starting at address 0, is the modulo region, and its size is the configuration value times one segment of 512 words. The rest of the memory, up to the last word, is plain linear memory.

The block holds an offset pointer. The pointer steps back by one word on every frame-start strobe and wraps inside the modulo region. When an access is flagged as modulo, its base is rotated by the pointer within the modulo region. When an access is flagged as direct, its base passes through unchanged. A value written through the configuration port takes effect at once and restarts the pointer. The result is registered, so it appears one clock after the request.

Top module: `modram_agen`

## Requirements
- R1: After the active-low asynchronous reset, `addr_vld_o`, `err_o` and `addr_o` are 0, the configuration equals NUM_SEG (the whole memory is modulo) and the offset pointer is 0.
- R2: The modulo region size is `cfg_val_i` × SEG_WORDS words. A written value above NUM_SEG is saturated to NUM_SEG.
- R3: A modulo access with base < size returns (base + offset) mod size on `addr_o`, with `err_o` low, one clock after the request.
- R4: Each `frame_i` strobe decrements the offset by one and wraps from 0 to size − 1.
- R5: A configuration write clears the offset to 0 at the same edge. An access in the same cycle as the write still uses the old size and offset.
- R6: A direct access (`acc_mod_i` = 0) with base below the memory size returns the base unchanged, with `err_o` low, whatever the offset.
- R7: A modulo access whose base is at or above a non-zero modulo size raises `err_o` and returns the base unchanged.
- R8: With a configuration value of 0, modulo accesses are treated as direct and `frame_i` leaves the offset at 0.
- R9: Any access whose base is at or beyond the memory size (NUM_SEG × SEG_WORDS) raises `err_o` and returns the base.
- R10: `addr_vld_o` is `acc_vld_i` delayed by one clock. While it is low, `addr_o` and `err_o` are 0.
- R11: When `cfg_we_i` and `frame_i` arrive in the same cycle, the write wins and the offset becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_val_i | input | CFG_W | Modulo size in segments |
| frame_i | input | 1 | Frame-start strobe that steps the offset |
| acc_vld_i | input | 1 | Access request |
| acc_mod_i | input | 1 | 1 = modulo access, 0 = direct |
| acc_base_i | input | AW | Base address of the access |
| addr_vld_o | output | 1 | Registered result valid |
| addr_o | output | AW | Physical RAM address |
| err_o | output | 1 | Out-of-region or out-of-memory access |

## Verification
The offset pointer cannot be seen directly, so a wrong pointer only shows up in the address a modulo access gets back. The bench therefore probes every base address, in both modes, at every pointer position of every configuration value. A wrong step, a wrong wrap or a missed clear then shows up in the first modulo access that follows the faulty frame strobe or write, one clock after that access. A wrong size decode shows up as a misplaced `err_o` boundary in the same sweep.

// File: rtl/modram_pkg.sv
package modram_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_LIN,
    ACC_MOD,
    ACC_ERR
  } acc_kind_e;
endpackage

// File: rtl/modram_cfg.sv
module modram_cfg #(
  parameter int SEG_WORDS = 512,
  parameter int NUM_SEG   = 12,
  parameter int CFG_W     = 4,
  parameter int SW        = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] val_i,
  output logic [SW-1:0]    size_o
);
  localparam logic [CFG_W-1:0] CfgMax = CFG_W'(NUM_SEG);

  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb cfg_d = (val_i > CfgMax) ? CfgMax : val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CfgMax;
    else if (we_i) cfg_q <= cfg_d;
  end

  assign size_o = SW'(cfg_q) * SW'(SEG_WORDS);
endmodule

// File: rtl/modram_ptr.sv
module modram_ptr #(
  parameter int SW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [SW-1:0] size_i,
  output logic [SW-1:0] ofs_o
);
  logic [SW-1:0] ofs_q;

  // write wins over frame step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ofs_q <= '0;
    else if (clr_i)                     ofs_q <= '0;
    else if (step_i && size_i != '0)    ofs_q <= (ofs_q == '0) ? size_i - 1'b1 : ofs_q - 1'b1;
  end

  assign ofs_o = ofs_q;
endmodule

// File: rtl/modram_map.sv
module modram_map
  import modram_pkg::*;
#(
  parameter int AW    = 13,
  parameter int SW    = 13,
  parameter int TOTAL = 6144
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          mod_i,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] ofs_i,
  input  logic [SW-1:0] size_i,
  output logic          vld_o,
  output logic [AW-1:0] addr_o,
  output logic          err_o
);
  logic [SW:0] base_x, sum, wrap, size_x;
  acc_kind_e   kind;

  always_comb begin
    base_x = (SW+1)'(base_i);
    size_x = {1'b0, size_i};
    sum    = base_x + {1'b0, ofs_i};
    wrap   = (sum >= size_x) ? sum - size_x : sum;
    if (!vld_i)                          kind = ACC_IDLE;
    else if (base_x >= (SW+1)'(TOTAL))   kind = ACC_ERR;
    else if (mod_i && size_i != '0)      kind = (base_x >= size_x) ? ACC_ERR : ACC_MOD;
    else                                 kind = ACC_LIN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      err_o  <= 1'b0;
    end else begin
      unique case (kind)
        ACC_IDLE: begin vld_o <= 1'b0; addr_o <= '0;         err_o <= 1'b0; end
        ACC_LIN:  begin vld_o <= 1'b1; addr_o <= base_i;     err_o <= 1'b0; end
        ACC_MOD:  begin vld_o <= 1'b1; addr_o <= AW'(wrap);  err_o <= 1'b0; end
        default:  begin vld_o <= 1'b1; addr_o <= base_i;     err_o <= 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/modram_agen.sv
module modram_agen #(
  parameter int SEG_WORDS = 512,
  parameter int NUM_SEG   = 12,
  localparam int TOTAL    = SEG_WORDS * NUM_SEG,
  localparam int AW       = $clog2(TOTAL),
  localparam int SW       = $clog2(TOTAL + 1),
  localparam int CFG_W    = $clog2(NUM_SEG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_val_i,
  input  logic             frame_i,
  input  logic             acc_vld_i,
  input  logic             acc_mod_i,
  input  logic [AW-1:0]    acc_base_i,
  output logic             addr_vld_o,
  output logic [AW-1:0]    addr_o,
  output logic             err_o
);
  logic [SW-1:0] size;
  logic [SW-1:0] ofs;

  modram_cfg #(
    .SEG_WORDS(SEG_WORDS), .NUM_SEG(NUM_SEG), .CFG_W(CFG_W), .SW(SW)
  ) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .val_i(cfg_val_i), .size_o(size)
  );

  modram_ptr #(.SW(SW)) u_ptr (
    .clk_i, .rst_ni, .clr_i(cfg_we_i), .step_i(frame_i), .size_i(size), .ofs_o(ofs)
  );

  modram_map #(.AW(AW), .SW(SW), .TOTAL(TOTAL)) u_map (
    .clk_i, .rst_ni,
    .vld_i(acc_vld_i), .mod_i(acc_mod_i), .base_i(acc_base_i),
    .ofs_i(ofs), .size_i(size),
    .vld_o(addr_vld_o), .addr_o(addr_o), .err_o(err_o)
  );
endmodule

// File: rtl/modram_agen_chk.sv
module modram_agen_chk #(
  parameter int SEG_WORDS = 512,
  parameter int NUM_SEG   = 12,
  localparam int TOTAL    = SEG_WORDS * NUM_SEG,
  localparam int AW       = $clog2(TOTAL),
  localparam int SW       = $clog2(TOTAL + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic          frame_i,
  input logic          acc_vld_i,
  input logic          acc_mod_i,
  input logic [AW-1:0] acc_base_i,
  input logic          addr_vld_o,
  input logic [AW-1:0] addr_o,
  input logic          err_o,
  input logic [SW-1:0] size_i,
  input logic [SW-1:0] ofs_i
);
  logic          past_ok;
  logic [SW:0]   base_x;
  assign base_x = (SW+1)'(acc_base_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_vld_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> addr_vld_o == $past(acc_vld_i));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_vld_o |-> (addr_o == '0 && !err_o));

  assert_ofs_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i != '0 |-> ofs_i < size_i);

  assert_ofs_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i == '0 |-> ofs_i == '0);

  assert_cfg_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(cfg_we_i) |-> ofs_i == '0);

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(frame_i && !cfg_we_i && size_i != '0) |->
      ofs_i == (($past(ofs_i) == '0) ? $past(size_i) - 1'b1 : $past(ofs_i) - 1'b1));

  assert_lin_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(acc_vld_i && !acc_mod_i && base_x < (SW+1)'(TOTAL)) |->
      (addr_o == $past(acc_base_i) && !err_o));

  assert_mod_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(acc_vld_i && acc_mod_i && size_i != '0 && base_x >= {1'b0, size_i}) |->
      (err_o && addr_o == $past(acc_base_i)));

  assert_mod_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(acc_vld_i && acc_mod_i && base_x < {1'b0, size_i}) |->
      (!err_o && (SW+1)'(addr_o) < {1'b0, $past(size_i)}));
endmodule

bind modram_agen modram_agen_chk #(.SEG_WORDS(SEG_WORDS), .NUM_SEG(NUM_SEG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .frame_i(frame_i),
  .acc_vld_i(acc_vld_i), .acc_mod_i(acc_mod_i), .acc_base_i(acc_base_i),
  .addr_vld_o(addr_vld_o), .addr_o(addr_o), .err_o(err_o),
  .size_i(size), .ofs_i(ofs)
);

// File: tb/modram_agen_bench.sv
module modram_agen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEG   = 8;
  localparam int NSEG  = 5;
  localparam int TOTAL = SEG * NSEG;
  localparam int AW    = $clog2(TOTAL);
  localparam int CW    = $clog2(NSEG + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_val = '0;
  logic          frame = 1'b0;
  logic          acc_vld = 1'b0;
  logic          acc_mod = 1'b0;
  logic [AW-1:0] acc_base = '0;
  logic          addr_vld;
  logic [AW-1:0] addr;
  logic          err;

  int checks = 0;
  int errors = 0;
  int m_cfg = NSEG;
  int m_ofs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modram_agen #(.SEG_WORDS(SEG), .NUM_SEG(NSEG)) u_modram_agen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_val_i(cfg_val),
    .frame_i(frame), .acc_vld_i(acc_vld), .acc_mod_i(acc_mod), .acc_base_i(acc_base),
    .addr_vld_o(addr_vld), .addr_o(addr), .err_o(err)
  );

  function automatic int msize();
    return m_cfg * SEG;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic update(bit fr, bit we, int val);
    if (we) begin
      m_cfg = (val > NSEG) ? NSEG : val;
      m_ofs = 0;
    end else if (fr && msize() != 0) begin
      m_ofs = (m_ofs == 0) ? msize() - 1 : m_ofs - 1;
    end
  endtask

  task automatic access(bit mod, int base, bit fr, bit we, int val, string tag);
    int e_addr, e_err;
    string req;
    @(negedge clk);
    acc_vld = 1'b1; acc_mod = mod; acc_base = AW'(base);
    frame = fr; cfg_we = we; cfg_val = CW'(val);
    e_addr = base; e_err = 0;
    if (base >= TOTAL) begin e_err = 1; req = "R9"; end
    else if (mod && msize() == 0) req = "R8";
    else if (mod && base >= msize()) begin e_err = 1; req = "R7"; end
    else if (mod) begin
      e_addr = (base + m_ofs) % msize();
      req = (m_ofs == 0) ? "R3" : "R4";
    end else req = "R6";
    if (tag != "") req = tag;
    @(posedge clk); #1;
    acc_vld = 1'b0; frame = 1'b0; cfg_we = 1'b0;
    chk(req, "addr_vld", int'(addr_vld), 1);
    chk(req, "addr", int'(addr), e_addr);
    chk(req, "err", int'(err), e_err);
    update(fr, we, val);
  endtask

  task automatic idle(bit fr, bit we, int val);
    @(negedge clk);
    frame = fr; cfg_we = we; cfg_val = CW'(val);
    @(posedge clk); #1;
    frame = 1'b0; cfg_we = 1'b0;
    chk("R10", "idle vld", int'(addr_vld), 0);
    chk("R10", "idle addr", int'(addr), 0);
    chk("R10", "idle err", int'(err), 0);
    update(fr, we, val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset vld", int'(addr_vld), 0);
    chk("R1", "reset addr", int'(addr), 0);
    chk("R1", "reset err", int'(err), 0);
    @(negedge clk); rst_n = 1'b1;
    // default: full memory modulo, offset 0
    access(1, 0, 0, 0, 0, "R1");
    access(1, TOTAL - 1, 0, 0, 0, "R1");
    access(1, TOTAL, 0, 0, 0, "R9");
    idle(0, 0, 0);
    // saturation of oversized value
    idle(0, 1, (1 << CW) - 1);
    access(1, TOTAL - 1, 0, 0, 0, "R2");
    access(1, TOTAL, 0, 0, 0, "R2");
    // full sweep: every config, every offset, every base, both modes
    for (int c = 0; c < (1 << CW); c++) begin
      int steps;
      idle(0, 1, c);
      steps = (msize() == 0) ? 3 : msize() + 2;
      for (int s = 0; s < steps; s++) begin
        for (int b = 0; b < (1 << AW); b++) begin
          access(1, b, 0, 0, 0, "");
          access(0, b, 0, 0, 0, "");
        end
        idle(1, 0, 0);
      end
    end
    // write with simultaneous access uses old state, then clears offset
    idle(0, 1, 3);
    idle(1, 0, 0);
    idle(1, 0, 0);
    access(1, 5, 0, 1, 2, "R5");
    access(1, 5, 0, 0, 0, "R5");
    access(1, 16, 0, 0, 0, "R5");
    // write and frame together: write wins
    idle(1, 0, 0);
    idle(1, 1, 4);
    access(1, 0, 0, 0, 0, "R11");
    // frame together with access: access sees old offset
    access(1, 0, 1, 0, 0, "R4");
    access(1, 0, 0, 0, 0, "R4");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule